// File: doc/BRIEF.md
# Event Interval Capture Timer

This block measures the elapsed time between successive external events that arrive with no relation to the system clock, for example the pulses a separate peak detector raises when it finds a signal maximum. A free-running time base advances once per tick enable (nominally a 10 kHz tick, so one count is 0.1 ms). Each rising edge of the event input, once brought into the clock domain, captures the time base and reports the number of ticks since the previous event.

The time base is split into a low counter and an extension counter that steps when the low counter wraps. Both halves are read on the same clock edge, so a capture can never mix an old low part with a new extension part. The interval is one modular subtraction of the stored capture from the new one. This covers intervals of about 1.5 s (15,000 counts) with a wide margin. A sticky flag warns when a full period of the time base has passed without an event, because the modular result is then ambiguous.

Top module: `event_interval_timer`

## Requirements
- R1: While rst_ni is low and after it rises, valid_o, overflow_o and interval_o are all 0, and the time base count is 0.
- R2: The time base is LO_W+HI_W bits wide (16 by default). The low part increments on each clock edge with tick_i high. The extension part increments on the edge where the low part wraps from all ones to 0. Without tick_i the count holds.
- R3: event_i passes through a two-flop synchronizer and a rising-edge detector. A rise that is first sampled at clock edge n gives a valid_o pulse after edge n+2, one clock wide. An event level held high for many cycles gives exactly one pulse.
- R4: On each detected event after the first, interval_o becomes (count at capture − count at previous capture) mod 2^16 and valid_o is high for that one cycle. interval_o then holds until the next capture.
- R5: The first event after reset only stores the count. valid_o stays low and interval_o keeps its value.
- R6: The low and extension parts are captured on the same edge. An interval that spans low-byte wraps, or the wrap of the full count from 65535 to 0, is reported exactly by the modular difference. Two events with no tick between them report 0.
- R7: overflow_o rises once 65,536 ticks have passed since the last event (or since reset) with no event in between. After 65,535 ticks it is still low. Once set, it stays high while no event occurs.
- R8: A detected event clears overflow_o on the edge where it captures. The same event still produces its valid_o and interval_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time base advance enable, one clock per tick |
| event_i | input | 1 | Asynchronous event level; its rising edge marks an event |
| interval_o | output | LO_W+HI_W | Ticks between the last two events, modulo 2^(LO_W+HI_W) |
| valid_o | output | 1 | One-cycle strobe when interval_o is updated |
| overflow_o | output | 1 | Sticky: a full time base period passed with no event |

## Verification
On every cycle the assertions check these properties:
- the carry from the low counter into the extension counter, and that the count holds without a tick;
- that every valid_o pulse follows a detected edge by one cycle, and that the priming event never strobes;
- that overflow_o stays sticky and clears on a capture.

The interval values themselves, the exact three-edge latency from the pin, the single pulse for a long event level, and the 65,535 versus 65,536 tick boundary of the overflow flag can only be shown by the bench's scenarios. The bench computes each of these arithmetically from the ticks it has applied.

// File: rtl/eit_pkg.sv
package eit_pkg;
  localparam int unsigned DEF_LO_W   = 8;
  localparam int unsigned DEF_HI_W   = 8;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum logic {
    CAP_EMPTY  = 1'b0,
    CAP_PRIMED = 1'b1
  } cap_state_e;
endpackage

// File: rtl/eit_sync_edge.sv
module eit_sync_edge #(
  parameter int unsigned STAGES = eit_pkg::DEF_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/eit_timebase.sv
module eit_timebase #(
  parameter int unsigned LO_W = eit_pkg::DEF_LO_W,
  parameter int unsigned HI_W = eit_pkg::DEF_HI_W,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap;

  assign lo_wrap = tick_i & (&lo_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lo_q <= '0;
    else if (tick_i) lo_q <= lo_q + LO_W'(1);
  end

  // extension steps only on the low wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (lo_wrap) hi_q <= hi_q + HI_W'(1);
  end

  assign count_o = {hi_q, lo_q};
endmodule

// File: rtl/eit_capture.sv
module eit_capture #(
  parameter int unsigned CNT_W = eit_pkg::DEF_LO_W + eit_pkg::DEF_HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] interval_o,
  output logic             valid_o,
  output logic             overflow_o,
  output logic             primed_o
);
  import eit_pkg::*;

  cap_state_e       state_q;
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] interval_q;
  logic             valid_q;
  logic [CNT_W-1:0] idle_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= CAP_EMPTY;
      prev_q     <= '0;
      interval_q <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (rise_i) begin
        state_q <= CAP_PRIMED;
        prev_q  <= count_i;
        if (state_q == CAP_PRIMED) begin
          interval_q <= count_i - prev_q;  // modular
          valid_q    <= 1'b1;
        end
      end
    end
  end

  // ticks since last event; full wrap marks overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      ovf_q  <= 1'b0;
    end else if (rise_i) begin
      idle_q <= '0;
      ovf_q  <= 1'b0;
    end else if (tick_i) begin
      idle_q <= idle_q + CNT_W'(1);
      if (&idle_q) ovf_q <= 1'b1;
    end
  end

  assign interval_o = interval_q;
  assign valid_o    = valid_q;
  assign overflow_o = ovf_q;
  assign primed_o   = (state_q == CAP_PRIMED);
endmodule

// File: rtl/event_interval_timer.sv
module event_interval_timer #(
  parameter int unsigned LO_W   = eit_pkg::DEF_LO_W,
  parameter int unsigned HI_W   = eit_pkg::DEF_HI_W,
  parameter int unsigned STAGES = eit_pkg::DEF_STAGES,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             event_i,
  output logic [CNT_W-1:0] interval_o,
  output logic             valid_o,
  output logic             overflow_o
);
  logic             ev_rise;
  logic [CNT_W-1:0] cnt;
  logic             primed;

  eit_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(event_i),
    .rise_o (ev_rise)
  );

  eit_timebase #(.LO_W(LO_W), .HI_W(HI_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .count_o(cnt)
  );

  eit_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rise_i    (ev_rise),
    .count_i   (cnt),
    .interval_o(interval_o),
    .valid_o   (valid_o),
    .overflow_o(overflow_o),
    .primed_o  (primed)
  );
endmodule

// File: rtl/eit_checker.sv
module eit_checker #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 8,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             rise,
  input logic             primed,
  input logic [CNT_W-1:0] count,
  input logic             valid_o,
  input logic             overflow_o
);
  a_r2_ext_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&count[LO_W-1:0])) |=>
      (count[CNT_W-1:LO_W] == $past(count[CNT_W-1:LO_W]) + HI_W'(1)))
    else $error("a_r2_ext_carry");

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count))
    else $error("a_r2_hold");

  a_r3_valid_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise))
    else $error("a_r3_valid_after_rise");

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o)
    else $error("a_r3_single_pulse");

  a_r4_capture_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && primed) |=> valid_o)
    else $error("a_r4_capture_strobes");

  a_r5_prime_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !primed) |=> !valid_o)
    else $error("a_r5_prime_silent");

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !rise) |=> overflow_o)
    else $error("a_r7_ovf_sticky");

  a_r8_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !overflow_o)
    else $error("a_r8_ovf_clear");
endmodule

bind event_interval_timer eit_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rise      (ev_rise),
  .primed    (primed),
  .count     (cnt),
  .valid_o   (valid_o),
  .overflow_o(overflow_o)
);

// File: tb/event_interval_timer_tb.sv
`timescale 1ns/1ps
module event_interval_timer_tb;
  localparam int CNT_W = 16;
  localparam int MOD   = 65536;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b0;
  logic             event_i = 1'b0;
  logic [CNT_W-1:0] interval_o;
  logic             valid_o;
  logic             overflow_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int cnt_model  = 0;  // time base value
  int prev_model = 0;
  int idle_model = 0;
  int last_intv  = 0;
  bit primed_m   = 1'b0;

  always #5 clk_i = ~clk_i;

  event_interval_timer u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .event_i   (event_i),
    .interval_o(interval_o),
    .valid_o   (valid_o),
    .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk_i); tick_i = 1'b1;
      repeat (n) @(posedge clk_i);
      @(negedge clk_i); tick_i = 1'b0;
      cnt_model  = (cnt_model + n) % MOD;
      idle_model = idle_model + n;
    end
  endtask

  // raise event for hold cycles, watch valid_o
  task automatic fire(input int hold, input string req);
    int pulses = 0;
    int first  = -1;
    int exp_i;
    @(negedge clk_i); event_i = 1'b1;
    for (int c = 1; c <= hold + 5; c++) begin
      @(negedge clk_i);
      if (c == hold) event_i = 1'b0;
      if (valid_o) begin
        pulses++;
        if (first < 0) first = c;
      end
    end
    if (primed_m) begin
      exp_i = (cnt_model - prev_model + MOD) % MOD;
      chk({req, " R3 pulse count"}, pulses, 1);
      chk({req, " R3 latency"}, first, 3);
      chk({req, " R4 interval"}, int'(interval_o), exp_i);
      last_intv = exp_i;
    end else begin
      chk({req, " R5 prime no pulse"}, pulses, 0);
      chk({req, " R5 interval kept"}, int'(interval_o), last_intv);
    end
    chk({req, " R8 overflow cleared"}, int'(overflow_o), 0);
    primed_m   = 1'b1;
    prev_model = cnt_model;
    idle_model = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 overflow in reset", int'(overflow_o), 0);
    chk("R1 interval in reset", int'(interval_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 valid after reset", int'(valid_o), 0);
    chk("R1 overflow after reset", int'(overflow_o), 0);

    // R5 priming event, R2 time base offset
    ticks(123);
    fire(2, "prime");

    // R4 sweep of intervals, R6 spans low-byte wraps
    for (int k = 1; k <= 16; k++) begin
      ticks((k * k * 53) % 1500);
      fire(1 + (k % 4), "sweep");
    end
    ticks(255); fire(2, "R2 one below wrap");
    ticks(256); fire(2, "R2 exact low wrap");
    ticks(1);   fire(2, "R2 single tick");
    fire(2, "R6 zero interval");
    ticks(15000); fire(2, "R4 max heart interval");

    // R3 long level gives a single pulse
    ticks(40);
    fire(20, "R3 long level");

    // R7 just below overflow, crosses full count wrap (R6)
    ticks(65535);
    chk("R7 no overflow at 65535", int'(overflow_o), 0);
    fire(2, "R6 R7 interval 65535");

    // R7 overflow at 65536, sticky
    ticks(65536);
    chk("R7 overflow at 65536", int'(overflow_o), 1);
    repeat (5) @(negedge clk_i);
    chk("R7 overflow sticky", int'(overflow_o), 1);
    ticks(7);
    chk("R7 overflow sticky ticks", int'(overflow_o), 1);
    fire(2, "R8 event after overflow");

    ticks(42); fire(2, "R4 after overflow");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule